// File: doc/BRIEF.md
# Vector Pooling and Normalization Unit

This block is the post-processing row that follows a matrix-multiply array. Each cycle it can take one vector of 32 signed 32-bit accumulator values, one lane per output channel. The vectors arrive as a stream, and each group of vectors ending in a `last` marker forms one pooling window. Every lane reduces its window to one value. The reduction is either the largest element or the running sum, selected for the whole run. The unit then applies a per-lane scale, a rounding right shift, a per-lane bias and an optional ReLU. It saturates the result to a signed byte and presents the 32 bytes as one output vector.

Pooling is always in the path. A layer without pooling is run as a one-element window, which reproduces its input. An inference-time batch normalization is folded into the per-lane scale and bias. Average pooling divides through the scale: software loads a fixed-point reciprocal of the window size, so the unit has no divider. Configuration is captured from the `cfg_*` inputs on a `cfg_load` pulse while the unit is idle, and it stays in force for the run.

Top module: `vpool_norm_unit`

## Requirements
- R1: Lane i takes input bits [32i+31:32i], scale bits [16i+15:16i] and bias bits [32i+31:32i], and drives output bits [8i+7:8i]. With a window count of 1, scale 1, shift 0, bias 0 and ReLU off, each output lane equals its input lane for inputs in -128..127. This holds in both pooling modes.
- R2: With `cfg_avg` = 0 (max mode), each lane's pooled value is the largest element of its window. The reduction is seeded from the first element, so a window whose elements are all negative yields its largest negative value.
- R3: With `cfg_avg` = 1 (average mode), each lane's pooled value is the exact sum of its window's elements, held to 40 bits. That sum is then multiplied by the lane's scale.
- R4: The 56-bit product of pooled value and signed 16-bit scale is shifted right arithmetically by `cfg_shift` (0..31). Ties round away from zero, and a shift of 0 leaves the product unchanged.
- R5: The lane's signed 32-bit bias is added after the shift.
- R6: When `cfg_relu` is 1, a negative biased value becomes 0 before saturation. When it is 0, negative values pass through.
- R7: The final value saturates to the range -128..127.
- R8: `err` is set when a window ends with a number of elements other than `cfg_count`. Windows longer than 255 elements never alias to a smaller count. Once set, `err` stays high until reset or the next `cfg_load`.
- R9: If `out_ready` is held high, the output vector for a window is presented with `out_valid` after the third clock edge that follows the edge that accepted the window's last element. In that case `in_ready` stays high, so a new window can start on the very next cycle.
- R10: While `out_valid` is high and `out_ready` is low, the output vector holds its value and `in_ready` is low. No window result is lost or reordered under backpressure.
- R11: After reset, `out_valid` and `err` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture all cfg_* inputs into the run registers |
| cfg_avg | input | 1 | 1 selects average pooling, 0 selects max pooling |
| cfg_relu | input | 1 | Enables the ReLU clamp |
| cfg_shift | input | 5 | Right shift applied after scaling |
| cfg_count | input | 8 | Expected elements per window (1..255) |
| cfg_scale | input | 512 | Per-lane signed 16-bit scale |
| cfg_bias | input | 1024 | Per-lane signed 32-bit bias |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Unit can accept an input vector |
| in_last | input | 1 | Marks the final element of a window |
| in_data | input | 1024 | 32 signed 32-bit accumulator lanes |
| out_valid | output | 1 | Output vector valid |
| out_ready | input | 1 | Downstream accepts the output vector |
| out_data | output | 256 | 32 signed 8-bit result lanes |
| err | output | 1 | Sticky window length mismatch flag |

## Verification
The hardest situation to reach is a stall that arrives while single-element windows stream in back to back. At that moment all four pipeline stages hold live results. The stimulus gets there by streaming runs of one-element and two-element windows while `out_ready` is driven from a random source. The length check past the counter's range needs a deliberate long window. The bench sends 300 elements against a configured count of 44, which a wrapping 8-bit counter would accept. It also sends an exactly 255-element window, which must pass.

// File: rtl/vpn_pkg.sv
package vpn_pkg;

  typedef enum logic {
    POOL_MAX = 1'b0,
    POOL_AVG = 1'b1
  } pool_mode_e;

  localparam int DEF_LANES   = 32;
  localparam int DEF_IN_W    = 32;
  localparam int DEF_SUM_W   = 40;
  localparam int DEF_SCALE_W = 16;
  localparam int DEF_BIAS_W  = 32;
  localparam int DEF_SHIFT_W = 5;
  localparam int DEF_CNT_W   = 8;
  localparam int DEF_OUT_W   = 8;

endpackage

// File: rtl/vpn_window_ctrl.sv
module vpn_window_ctrl #(
  parameter int CNT_W = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] win_count,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             accept,
  output logic             first_elem,
  output logic             win_done,
  output logic             adv,
  output logic             out_valid,
  output logic             err
);

  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] CNT_CAP = CW'(1) << CNT_W;

  logic [CW-1:0]    cnt_q;
  logic [DEPTH-1:0] vld_q;
  logic [CW-1:0]    cnt_inc;
  logic             len_bad;

  assign out_valid  = vld_q[DEPTH-1];
  assign adv        = !out_valid || out_ready;
  assign in_ready   = adv;
  assign accept     = in_valid && adv;
  assign win_done   = accept && in_last;
  assign first_elem = (cnt_q == '0);
  assign cnt_inc    = cnt_q + CW'(1);
  assign len_bad    = (cnt_inc != CW'(win_count));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (accept) begin
      if (in_last)               cnt_q <= '0;
      else if (cnt_q != CNT_CAP) cnt_q <= cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vld_q <= '0;
    else if (adv)      vld_q <= {vld_q[DEPTH-2:0], win_done};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   err <= 1'b0;
    else if (cfg_load)            err <= 1'b0;
    else if (win_done && len_bad) err <= 1'b1;
  end

endmodule

// File: rtl/vpn_lane_pool.sv
module vpn_lane_pool #(
  parameter int IN_W  = 32,
  parameter int SUM_W = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    first_elem,
  input  logic                    avg_mode,
  input  logic signed [IN_W-1:0]  x,
  output logic signed [SUM_W-1:0] pooled
);

  logic signed [SUM_W-1:0] acc_q;

  function automatic logic signed [SUM_W-1:0] pool_step(
    input logic signed [SUM_W-1:0] acc,
    input logic signed [IN_W-1:0]  v,
    input logic                    seed,
    input logic                    avg
  );
    logic signed [SUM_W-1:0] vs;
    vs = SUM_W'(v);
    if (seed)        return vs;
    else if (avg)    return acc + vs;
    else if (vs > acc) return vs;
    else             return acc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (take) acc_q <= pool_step(acc_q, x, first_elem, avg_mode);
  end

  assign pooled = acc_q;

endmodule

// File: rtl/vpn_lane_norm.sv
module vpn_lane_norm #(
  parameter int SUM_W   = 40,
  parameter int SCALE_W = 16,
  parameter int BIAS_W  = 32,
  parameter int SHIFT_W = 5,
  parameter int OUT_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adv,
  input  logic signed [SUM_W-1:0]   pooled,
  input  logic signed [SCALE_W-1:0] scale,
  input  logic signed [BIAS_W-1:0]  bias,
  input  logic [SHIFT_W-1:0]        shift,
  input  logic                      relu,
  output logic [OUT_W-1:0]          y
);

  localparam int PROD_W = SUM_W + SCALE_W;
  localparam int NORM_W = PROD_W + 1;
  localparam int OMAX_I = (1 << (OUT_W - 1)) - 1;
  localparam logic signed [NORM_W-1:0] OMAX = NORM_W'(OMAX_I);
  localparam logic signed [NORM_W-1:0] OMIN = NORM_W'(-OMAX_I - 1);
  localparam logic signed [PROD_W-1:0] ONE  = PROD_W'(1);

  logic signed [PROD_W-1:0] prod_q;
  logic signed [NORM_W-1:0] sum_q;
  logic [OUT_W-1:0]         y_q;

  // ties go away from zero; negatives borrow one before the floor shift
  function automatic logic signed [PROD_W-1:0] round_shift(
    input logic signed [PROD_W-1:0] p,
    input logic [SHIFT_W-1:0]       s
  );
    logic signed [PROD_W-1:0] half;
    half = '0;
    if (s == '0) return p;
    half[s - SHIFT_W'(1)] = 1'b1;
    if (p[PROD_W-1]) return (p + half - ONE) >>> s;
    else             return (p + half) >>> s;
  endfunction

  function automatic logic [OUT_W-1:0] clamp(
    input logic signed [NORM_W-1:0] v,
    input logic                     rl
  );
    if (rl && v[NORM_W-1]) return '0;
    else if (v > OMAX)     return OMAX[OUT_W-1:0];
    else if (v < OMIN)     return OMIN[OUT_W-1:0];
    else                   return v[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      sum_q  <= '0;
      y_q    <= '0;
    end else if (adv) begin
      prod_q <= PROD_W'(pooled) * PROD_W'(scale);
      sum_q  <= NORM_W'(round_shift(prod_q, shift)) + NORM_W'(bias);
      y_q    <= clamp(sum_q, relu);
    end
  end

  assign y = y_q;

endmodule

// File: rtl/vpool_norm_unit.sv
module vpool_norm_unit import vpn_pkg::*; #(
  parameter int LANES   = DEF_LANES,
  parameter int IN_W    = DEF_IN_W,
  parameter int SUM_W   = DEF_SUM_W,
  parameter int SCALE_W = DEF_SCALE_W,
  parameter int BIAS_W  = DEF_BIAS_W,
  parameter int SHIFT_W = DEF_SHIFT_W,
  parameter int CNT_W   = DEF_CNT_W,
  parameter int OUT_W   = DEF_OUT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_load,
  input  logic                       cfg_avg,
  input  logic                       cfg_relu,
  input  logic [SHIFT_W-1:0]         cfg_shift,
  input  logic [CNT_W-1:0]           cfg_count,
  input  logic [LANES*SCALE_W-1:0]   cfg_scale,
  input  logic [LANES*BIAS_W-1:0]    cfg_bias,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_last,
  input  logic [LANES*IN_W-1:0]      in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [LANES*OUT_W-1:0]     out_data,
  output logic                       err
);

  localparam int PIPE_DEPTH = 4;

  pool_mode_e                 mode_q;
  logic                       relu_q;
  logic [SHIFT_W-1:0]         shift_q;
  logic [CNT_W-1:0]           count_q;
  logic [LANES*SCALE_W-1:0]   scale_q;
  logic [LANES*BIAS_W-1:0]    bias_q;

  logic accept;
  logic first_elem;
  logic win_done;
  logic adv;
  logic avg_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= POOL_MAX;
      relu_q  <= 1'b0;
      shift_q <= '0;
      count_q <= CNT_W'(1);
      scale_q <= {LANES{SCALE_W'(1)}};
      bias_q  <= '0;
    end else if (cfg_load) begin
      mode_q  <= cfg_avg ? POOL_AVG : POOL_MAX;
      relu_q  <= cfg_relu;
      shift_q <= cfg_shift;
      count_q <= cfg_count;
      scale_q <= cfg_scale;
      bias_q  <= cfg_bias;
    end
  end

  assign avg_on = (mode_q == POOL_AVG);

  vpn_window_ctrl #(
    .CNT_W (CNT_W),
    .DEPTH (PIPE_DEPTH)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .win_count  (count_q),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .accept     (accept),
    .first_elem (first_elem),
    .win_done   (win_done),
    .adv        (adv),
    .out_valid  (out_valid),
    .err        (err)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [SUM_W-1:0] pooled;

    vpn_lane_pool #(
      .IN_W  (IN_W),
      .SUM_W (SUM_W)
    ) u_pool (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (accept),
      .first_elem (first_elem),
      .avg_mode   (avg_on),
      .x          (in_data[i*IN_W +: IN_W]),
      .pooled     (pooled)
    );

    vpn_lane_norm #(
      .SUM_W   (SUM_W),
      .SCALE_W (SCALE_W),
      .BIAS_W  (BIAS_W),
      .SHIFT_W (SHIFT_W),
      .OUT_W   (OUT_W)
    ) u_norm (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .pooled (pooled),
      .scale  (scale_q[i*SCALE_W +: SCALE_W]),
      .bias   (bias_q[i*BIAS_W +: BIAS_W]),
      .shift  (shift_q),
      .relu   (relu_q),
      .y      (out_data[i*OUT_W +: OUT_W])
    );
  end

endmodule

// File: rtl/vpn_checks.sv
module vpn_checks #(
  parameter int LANES = 32,
  parameter int OUT_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_load,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES*OUT_W-1:0] out_data,
  input logic                   err,
  input logic                   win_done,
  input logic                   relu_en
);

  logic [LANES-1:0] sign_bits;
  logic [2:0]       pend_q;
  logic             take_out;

  for (genvar i = 0; i < LANES; i++) begin : g_sign
    assign sign_bits[i] = out_data[i*OUT_W + OUT_W - 1];
  end

  assign take_out = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_q + 3'(win_done) - 3'(take_out);
  end

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err && !cfg_load |=> err);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(win_done));

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !err);

  assert_relu_nonneg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && relu_en |-> sign_bits == '0);

  assert_output_has_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pend_q != 3'd0);

  assert_pending_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= 3'd4);

  assert_accept_when_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

bind vpool_norm_unit vpn_checks #(
  .LANES (LANES),
  .OUT_W (OUT_W)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_load  (cfg_load),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .err       (err),
  .win_done  (win_done),
  .relu_en   (relu_q)
);

// File: tb/vpool_norm_unit_bench.sv
`timescale 1ns/1ps
module vpool_norm_unit_bench;

  localparam int L = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            cfg_load = 1'b0;
  logic            cfg_avg = 1'b0;
  logic            cfg_relu = 1'b0;
  logic [4:0]      cfg_shift = '0;
  logic [7:0]      cfg_count = 8'd1;
  logic [L*16-1:0] cfg_scale = '0;
  logic [L*32-1:0] cfg_bias = '0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic            in_last = 1'b0;
  logic [L*32-1:0] in_data = '0;
  logic            out_valid;
  logic            out_ready;
  logic [L*8-1:0]  out_data;
  logic            err;

  vpool_norm_unit u_vpool_norm_unit (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_avg(cfg_avg),
    .cfg_relu(cfg_relu), .cfg_shift(cfg_shift), .cfg_count(cfg_count),
    .cfg_scale(cfg_scale), .cfg_bias(cfg_bias), .in_valid(in_valid),
    .in_ready(in_ready), .in_last(in_last), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .err(err)
  );

  int     checks = 0;
  int     fails  = 0;
  int     cyc    = 0;
  bit     rand_ready = 1'b0;
  string  cur_req = "R1";

  // mirror of the loaded configuration
  bit     b_avg, b_relu;
  int     b_shift;
  longint b_scale[L];
  longint b_bias[L];

  // behavioural model state
  longint run[L];
  int     ecount = 0;
  logic [L*8-1:0] exp_q[$];
  int     due_q[$];

  always @(posedge clk) begin
    #1;
    out_ready = rand_ready ? ($urandom_range(3) != 0) : 1'b1;
  end

  function automatic int ref_norm(longint pooled, longint sc, int sh, longint bi, bit relu);
    longint p, mag, v;
    p = pooled * sc;
    if (sh > 0) begin
      mag = (p < 0) ? -p : p;
      mag = (mag + (longint'(1) <<< (sh - 1))) >>> sh;
      p = (p < 0) ? -mag : mag;
    end
    v = p + bi;
    if (relu && v < 0) v = 0;
    if (v > 127) v = 127;
    if (v < -128) v = -128;
    return int'(v);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor and reference model, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!rand_ready) begin
        bit exp_v;
        exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
        if (out_valid || exp_v) begin
          checks++;
          if (out_valid !== exp_v) begin
            fails++;
            $display("FAIL R9 output timing (%s): out_valid=%0b expected %0b at cycle %0d",
                     cur_req, out_valid, exp_v, cyc);
          end else if (out_data !== exp_q[0]) begin
            fails++;
            $display("FAIL %s result vector: got %h expected %h", cur_req, out_data, exp_q[0]);
          end
          if (exp_v) begin
            void'(exp_q.pop_front());
            void'(due_q.pop_front());
          end
        end
        if (in_valid && !in_ready)
          chk(1'b0, "R9", "in_ready dropped with out_ready high", 0, 1);
      end else begin
        if (out_valid && out_ready) begin
          checks++;
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R10 unexpected output: got %h expected none", out_data);
          end else begin
            if (out_data !== exp_q[0]) begin
              fails++;
              $display("FAIL R10 result under backpressure: got %h expected %h", out_data, exp_q[0]);
            end
            void'(exp_q.pop_front());
            void'(due_q.pop_front());
          end
        end
        if (out_valid && !out_ready)
          chk(in_ready == 1'b0, "R10", "in_ready while stalled", longint'(in_ready), 0);
      end
      if (in_valid && in_ready) begin
        for (int i = 0; i < L; i++) begin
          longint x;
          x = longint'($signed(in_data[i*32 +: 32]));
          if (ecount == 0)    run[i] = x;
          else if (b_avg)     run[i] = run[i] + x;
          else if (x > run[i]) run[i] = x;
        end
        ecount++;
        if (in_last) begin
          logic [L*8-1:0] ev;
          for (int i = 0; i < L; i++) begin
            int r;
            r = ref_norm(run[i], b_scale[i], b_shift, b_bias[i], b_relu);
            ev[i*8 +: 8] = r[7:0];
          end
          exp_q.push_back(ev);
          due_q.push_back(cyc + 4);
          ecount = 0;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_cfg(bit avg, bit relu, int sh, int cnt,
                          int sc0, int scs, int bi0, int bis);
    cfg_avg   = avg;
    cfg_relu  = relu;
    cfg_shift = sh[4:0];
    cfg_count = cnt[7:0];
    for (int i = 0; i < L; i++) begin
      int sc, bi;
      sc = sc0 + i * scs;
      bi = bi0 + i * bis;
      cfg_scale[i*16 +: 16] = sc[15:0];
      cfg_bias[i*32 +: 32]  = bi;
      b_scale[i] = longint'($signed(sc[15:0]));
      b_bias[i]  = longint'(bi);
    end
    b_avg = avg; b_relu = relu; b_shift = sh;
    cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
  endtask

  function automatic int gen_val(int kind);
    case (kind)
      0: return int'($urandom_range(200)) - 100;
      1: return -1 - int'($urandom_range(119));
      2: return int'($urandom);
      default: return int'($urandom_range(16)) - 8;
    endcase
  endfunction

  task automatic send_win(int n, int kind);
    for (int e = 0; e < n; e++) begin
      bit got;
      for (int i = 0; i < L; i++) in_data[i*32 +: 32] = gen_val(kind);
      in_valid = 1'b1;
      in_last  = (e == n - 1);
      got = 1'b0;
      while (!got) begin
        @(negedge clk);
        got = in_ready;
        tick();
      end
    end
  endtask

  task automatic idle_drain();
    int w;
    in_valid = 1'b0;
    in_last  = 1'b0;
    w = 0;
    while (exp_q.size() != 0 && w < 80) begin
      tick();
      w++;
    end
    chk(exp_q.size() == 0, cur_req, "windows left undelivered", exp_q.size(), 0);
    tick();
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < L; i++) begin b_scale[i] = 1; b_bias[i] = 0; run[i] = 0; end
    b_avg = 0; b_relu = 0; b_shift = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "out_valid after reset", longint'(out_valid), 0);
    chk(err == 1'b0,       "R11", "err after reset",       longint'(err), 0);
    chk(in_ready == 1'b1,  "R11", "in_ready after reset",  longint'(in_ready), 1);
    tick();

    // R1: identity through 1x1 windows, back to back (also R9 streaming)
    cur_req = "R1";
    load_cfg(0, 0, 0, 1, 1, 0, 0, 0);
    for (int k = 0; k < 24; k++) send_win(1, 0);
    idle_drain();
    load_cfg(1, 0, 0, 1, 1, 0, 0, 0);
    for (int k = 0; k < 8; k++) send_win(1, 0);
    idle_drain();

    // R2: max mode with all-negative windows
    cur_req = "R2";
    load_cfg(0, 0, 0, 5, 1, 0, 0, 0);
    for (int k = 0; k < 6; k++) send_win(5, 1);
    idle_drain();

    // R3: average via reciprocal scale, per-lane scales differ
    cur_req = "R3";
    load_cfg(1, 0, 16, 4, 16384, 100, 0, 0);
    for (int k = 0; k < 6; k++) send_win(4, 0);
    idle_drain();

    // R4, R5: rounding of small products with signed scales and biases
    cur_req = "R4_R5";
    load_cfg(0, 0, 2, 1, -7, 1, -20, 1);
    for (int k = 0; k < 10; k++) send_win(1, 3);
    idle_drain();
    load_cfg(0, 0, 1, 1, 3, -1, 2, 0);
    for (int k = 0; k < 10; k++) send_win(1, 3);
    idle_drain();

    // R6: ReLU with negative bias
    cur_req = "R6";
    load_cfg(0, 1, 0, 2, 1, 0, -10, 0);
    for (int k = 0; k < 8; k++) send_win(2, 0);
    idle_drain();

    // R7: saturation at both ends, also full-range inputs
    cur_req = "R7";
    load_cfg(1, 0, 0, 3, 1000, 7, 0, 0);
    for (int k = 0; k < 6; k++) send_win(3, 0);
    idle_drain();
    load_cfg(1, 0, 31, 3, 32767, -1000, 3, 0);
    for (int k = 0; k < 6; k++) send_win(3, 2);
    idle_drain();

    // R8: window length check
    cur_req = "R8";
    load_cfg(0, 0, 0, 3, 1, 0, 0, 0);
    send_win(2, 0);
    chk(err == 1'b1, "R8", "err after short window", longint'(err), 1);
    send_win(3, 0);
    chk(err == 1'b1, "R8", "err sticky after good window", longint'(err), 1);
    idle_drain();
    load_cfg(0, 0, 0, 3, 1, 0, 0, 0);
    chk(err == 1'b0, "R8", "err cleared by cfg_load", longint'(err), 0);
    send_win(3, 0);
    chk(err == 1'b0, "R8", "err after matching window", longint'(err), 0);
    idle_drain();
    load_cfg(1, 0, 8, 44, 1, 0, 0, 0);
    send_win(300, 2);
    chk(err == 1'b1, "R8", "err after 300 elements vs 44", longint'(err), 1);
    idle_drain();
    load_cfg(1, 0, 30, 255, 5, 0, 0, 0);
    send_win(255, 2);
    chk(err == 1'b0, "R8", "err after 255-element window", longint'(err), 0);
    idle_drain();

    // R10: random backpressure with dense windows
    cur_req = "R10";
    rand_ready = 1'b1;
    load_cfg(0, 0, 1, 2, 3, 0, 5, 0);
    for (int k = 0; k < 30; k++) send_win(2, 0);
    idle_drain();
    load_cfg(1, 0, 0, 1, 1, 0, 0, 0);
    for (int k = 0; k < 30; k++) send_win(1, 0);
    idle_drain();
    rand_ready = 1'b0;
    tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule